// File: doc/BRIEF.md
# Address-Alias Memory Scan Tester

This block is a bus master that drives a word-addressed memory to find faults that let the memory accept a write and still return wrong data. Such faults include a broken or shorted address line that folds one location onto another, and a location that does not keep what was written to it. On a start pulse the block first stores a fixed reference word at address 0. It then walks upward from address 1 to a limit taken when the run starts. At each address N it does three things in order: it writes a word that is unique to N, it reads address 0 to confirm that the write did not land there, and it reads N back.

The run stops at the first mismatch. The block then latches the failing address, the expected word, the word actually read and a code for the check that tripped. These values stay on the status outputs until the next start. A run with no mismatch ends with done high and fail low. The memory port is a plain request/acknowledge handshake. The master holds a request, with its address, direction and write data, until the memory acknowledges it. Read data is taken in the acknowledge cycle.

Top module: `alias_scan_tester`

## Requirements
- R1: While reset is asserted and after its release, done, fail and mem_req are low, and fail_kind, fail_addr, fail_exp and fail_got are zero.
- R2: The first bus transfer after an accepted start is a write of 0x9BAB55AA to address 0.
- R3: For N = 1 up to scan_limit in ascending order, the block issues three transfers: a write of (0x6454AA55 XOR N) to address N, then a read of address 0, then a read of address N. It issues no other transfers.
- R4: If the read of address 0 after writing N returns something other than 0x9BAB55AA, the block sets fail with fail_kind = 2'b01, fail_addr = N, fail_exp = 0x9BAB55AA and fail_got = the word read.
- R5: If the read of address N returns something other than (0x6454AA55 XOR N), the block sets fail with fail_kind = 2'b10, fail_addr = N, fail_exp = that pattern and fail_got = the word read.
- R6: On the first failure, done and fail both rise in the cycle after the failing acknowledge, and no further request is issued.
- R7: If every address passes, done rises and fail stays low after the read of address scan_limit. With scan_limit = 0, the run is the single write to address 0 and then done.
- R8: done, fail and the captured fields hold until the next start. A start is accepted only when the block is idle or finished. An accepted start clears done, fail and the captured fields in the next cycle.
- R9: A request holds mem_we, mem_addr and mem_wdata steady until mem_ack arrives, and only one transfer is outstanding at a time.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | One-cycle pulse that begins a run |
| scan_limit | input | ADDR_W | Highest address scanned, taken when a start is accepted |
| mem_req | output | 1 | Transfer request |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | ADDR_W | Word address |
| mem_wdata | output | DATA_W | Write data |
| mem_ack | input | 1 | Transfer complete; read data is valid in this cycle |
| mem_rdata | input | DATA_W | Read data |
| done | output | 1 | Run finished, with a pass or a failure |
| fail | output | 1 | A mismatch was found |
| fail_kind | output | 2 | 01 = address-0 disturbed, 10 = readback mismatch |
| fail_addr | output | ADDR_W | Address N at which the failure occurred |
| fail_exp | output | DATA_W | Expected word |
| fail_got | output | DATA_W | Word actually read |

## Verification
A wrong sequencer state or a wrong address counter shows up directly on the bus. The transfer order is checked against the write-N, read-0, read-N pattern, so one skipped, repeated or misaddressed transfer is reported at the acknowledge where it occurs. A fault in the compare or capture logic is seen one cycle after the failing acknowledge: done and fail rise with the wrong code, address or words, or the run keeps issuing requests. Capture fields that do not hold are caught by re-reading them many cycles after the run stops, and again just after a restart.

// File: rtl/alias_scan_pkg.sv
package alias_scan_pkg;
  localparam logic [31:0] REF_WORD  = 32'h9BAB55AA;
  localparam logic [31:0] BASE_WORD = 32'h6454AA55;

  typedef enum logic [2:0] {
    ST_IDLE, ST_W0, ST_WN, ST_R0, ST_RN, ST_FIN
  } seq_state_t;

  localparam logic [1:0] KIND_NONE = 2'b00;
  localparam logic [1:0] KIND_ZERO = 2'b01;
  localparam logic [1:0] KIND_READ = 2'b10;
endpackage

// File: rtl/alias_scan_pattern.sv
module alias_scan_pattern #(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 32
) (
  input  logic [ADDR_W-1:0] addr_i,
  output logic [DATA_W-1:0] word_o
);
  import alias_scan_pkg::*;
  always_comb begin
    word_o = DATA_W'(BASE_WORD) ^ DATA_W'(addr_i);
  end
endmodule

// File: rtl/alias_scan_capture.sv
module alias_scan_capture #(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr_i,
  input  logic              en_i,
  input  logic [1:0]        kind_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] exp_i,
  input  logic [DATA_W-1:0] got_i,
  output logic              fail_o,
  output logic [1:0]        kind_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic [DATA_W-1:0] exp_o,
  output logic [DATA_W-1:0] got_o
);
  logic              fail_d;
  logic [1:0]        kind_d;
  logic [ADDR_W-1:0] addr_d;
  logic [DATA_W-1:0] exp_d, got_d;

  always_comb begin
    fail_d = fail_o;
    kind_d = kind_o;
    addr_d = addr_o;
    exp_d  = exp_o;
    got_d  = got_o;
    if (clr_i) begin
      fail_d = 1'b0;
      kind_d = '0;
      addr_d = '0;
      exp_d  = '0;
      got_d  = '0;
    end else if (en_i && !fail_o) begin
      fail_d = 1'b1;
      kind_d = kind_i;
      addr_d = addr_i;
      exp_d  = exp_i;
      got_d  = got_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fail_o <= 1'b0;
      kind_o <= '0;
      addr_o <= '0;
      exp_o  <= '0;
      got_o  <= '0;
    end else begin
      fail_o <= fail_d;
      kind_o <= kind_d;
      addr_o <= addr_d;
      exp_o  <= exp_d;
      got_o  <= got_d;
    end
  end

  // R8: captured record frozen until a clear
  p_fields_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    fail_o && !clr_i |=> fail_o && $stable(kind_o) && $stable(addr_o)
                         && $stable(exp_o) && $stable(got_o));
  // R4 / R5: a latched failure always carries one of the two codes
  p_kind_legal_r4: assert property (@(posedge clk) disable iff (!rst_n)
    fail_o |-> (kind_o == 2'b01 || kind_o == 2'b10));
  // R5: readback failures record a nonzero address
  p_read_addr_r5: assert property (@(posedge clk) disable iff (!rst_n)
    fail_o && kind_o == 2'b10 |-> addr_o != '0);
endmodule

// File: rtl/alias_scan_fsm.sv
module alias_scan_fsm #(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic [ADDR_W-1:0] limit_i,
  input  logic [DATA_W-1:0] pat_i,
  output logic [ADDR_W-1:0] cur_o,
  output logic              req_o,
  output logic              we_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic [DATA_W-1:0] wdata_o,
  input  logic              ack_i,
  input  logic [DATA_W-1:0] rdata_i,
  output logic              done_o,
  output logic              clr_o,
  output logic              cap_en_o,
  output logic [1:0]        cap_kind_o,
  output logic [DATA_W-1:0] cap_exp_o
);
  import alias_scan_pkg::*;
  localparam logic [DATA_W-1:0] REF_W = DATA_W'(REF_WORD);

  seq_state_t        state_q, state_d;
  logic [ADDR_W-1:0] cur_q, cur_d, limit_q, limit_d;
  logic              done_d, start_ok;

  assign cur_o    = cur_q;
  assign start_ok = start_i && (state_q == ST_IDLE || state_q == ST_FIN);
  assign clr_o    = start_ok;

  always_comb begin
    state_d    = state_q;
    cur_d      = cur_q;
    limit_d    = limit_q;
    done_d     = done_o;
    cap_en_o   = 1'b0;
    cap_kind_o = KIND_NONE;
    cap_exp_o  = '0;
    case (state_q)
      ST_IDLE, ST_FIN: begin
        if (start_ok) begin
          state_d = ST_W0;
          done_d  = 1'b0;
          limit_d = limit_i;
          cur_d   = ADDR_W'(1);
        end
      end
      ST_W0: if (ack_i) begin
        if (limit_q == '0) begin
          state_d = ST_FIN;
          done_d  = 1'b1;
        end else begin
          state_d = ST_WN;
        end
      end
      ST_WN: if (ack_i) state_d = ST_R0;
      ST_R0: if (ack_i) begin
        if (rdata_i != REF_W) begin
          cap_en_o   = 1'b1;
          cap_kind_o = KIND_ZERO;
          cap_exp_o  = REF_W;
          state_d    = ST_FIN;
          done_d     = 1'b1;
        end else begin
          state_d = ST_RN;
        end
      end
      ST_RN: if (ack_i) begin
        if (rdata_i != pat_i) begin
          cap_en_o   = 1'b1;
          cap_kind_o = KIND_READ;
          cap_exp_o  = pat_i;
          state_d    = ST_FIN;
          done_d     = 1'b1;
        end else if (cur_q == limit_q) begin
          state_d = ST_FIN;
          done_d  = 1'b1;
        end else begin
          cur_d   = cur_q + ADDR_W'(1);
          state_d = ST_WN;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_comb begin
    req_o   = (state_q == ST_W0) || (state_q == ST_WN) ||
              (state_q == ST_R0) || (state_q == ST_RN);
    we_o    = (state_q == ST_W0) || (state_q == ST_WN);
    addr_o  = (state_q == ST_W0 || state_q == ST_R0) ? '0 : cur_q;
    wdata_o = (state_q == ST_W0) ? REF_W : pat_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cur_q   <= '0;
      limit_q <= '0;
      done_o  <= 1'b0;
    end else begin
      state_q <= state_d;
      cur_q   <= cur_d;
      limit_q <= limit_d;
      done_o  <= done_d;
    end
  end

  // R9: request fields steady until acknowledged
  p_req_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    req_o && !ack_i |=> req_o && $stable(we_o) && $stable(addr_o) && $stable(wdata_o));
  // R6: no bus activity once finished
  p_quiet_when_done_r6: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> !req_o);
  // R2: accepted start leads to the reference write at address 0
  p_first_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
    start_ok |=> req_o && we_o && addr_o == '0 && wdata_o == REF_W);
  // R3: scanned addresses never pass the latched limit
  p_scan_range_r3: assert property (@(posedge clk) disable iff (!rst_n)
    req_o && addr_o != '0 |-> addr_o <= limit_q);
endmodule

// File: rtl/alias_scan_tester.sv
module alias_scan_tester #(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [ADDR_W-1:0] scan_limit,
  output logic              mem_req,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  input  logic              mem_ack,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic              done,
  output logic              fail,
  output logic [1:0]        fail_kind,
  output logic [ADDR_W-1:0] fail_addr,
  output logic [DATA_W-1:0] fail_exp,
  output logic [DATA_W-1:0] fail_got
);
  logic [ADDR_W-1:0] cur;
  logic [DATA_W-1:0] pat, cap_exp;
  logic              clr, cap_en;
  logic [1:0]        cap_kind;

  alias_scan_pattern #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_pat (
    .addr_i(cur), .word_o(pat)
  );

  alias_scan_fsm #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_fsm (
    .clk(clk), .rst_n(rst_n), .start_i(start), .limit_i(scan_limit),
    .pat_i(pat), .cur_o(cur), .req_o(mem_req), .we_o(mem_we),
    .addr_o(mem_addr), .wdata_o(mem_wdata), .ack_i(mem_ack),
    .rdata_i(mem_rdata), .done_o(done), .clr_o(clr), .cap_en_o(cap_en),
    .cap_kind_o(cap_kind), .cap_exp_o(cap_exp)
  );

  alias_scan_capture #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_cap (
    .clk(clk), .rst_n(rst_n), .clr_i(clr), .en_i(cap_en),
    .kind_i(cap_kind), .addr_i(cur), .exp_i(cap_exp), .got_i(mem_rdata),
    .fail_o(fail), .kind_o(fail_kind), .addr_o(fail_addr),
    .exp_o(fail_exp), .got_o(fail_got)
  );

  // R6: a failure always comes with done
  p_fail_has_done_r6: assert property (@(posedge clk) disable iff (!rst_n)
    fail |-> done);
endmodule

// File: tb/alias_scan_tester_bench.sv
module alias_scan_tester_bench;
  localparam int AW = 16;
  localparam int DW = 32;
  localparam logic [31:0] REFW = 32'h9BAB55AA;
  localparam logic [31:0] BASEW = 32'h6454AA55;

  logic clk = 1'b0;
  logic rst_n, start;
  logic [AW-1:0] scan_limit;
  logic mem_req, mem_we, mem_ack;
  logic [AW-1:0] mem_addr;
  logic [DW-1:0] mem_wdata, mem_rdata;
  logic done, fail;
  logic [1:0] fail_kind;
  logic [AW-1:0] fail_addr;
  logic [DW-1:0] fail_exp, fail_got;

  int total = 0, bad = 0;

  always #2.5 clk = ~clk;

  alias_scan_tester #(.ADDR_W(AW), .DATA_W(DW)) u_alias_scan_tester (
    .clk(clk), .rst_n(rst_n), .start(start), .scan_limit(scan_limit),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_ack(mem_ack), .mem_rdata(mem_rdata),
    .done(done), .fail(fail), .fail_kind(fail_kind), .fail_addr(fail_addr),
    .fail_exp(fail_exp), .fail_got(fail_got)
  );

  // memory model with fault injection
  logic [31:0] mem [256];
  logic [7:0]  alias_mask;
  int          drop_addr;
  int          n_wr, n_rd, n_seq_err, n_late_req;
  int          t_idx;

  function automatic logic [31:0] pat_of(int n);
    return BASEW ^ 32'(n);
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mem_ack   <= 1'b0;
      mem_rdata <= '0;
    end else begin
      mem_ack <= mem_req && !mem_ack;
      if (done && mem_req) n_late_req <= n_late_req + 1;
      if (mem_req && !mem_ack) begin
        // R3: expected transaction t: 0 -> W0; else k=(t-1)/3+1, phase W k, R 0, R k
        begin
          int k, ph;
          logic exp_we;
          int exp_a;
          logic [31:0] exp_d;
          if (t_idx == 0) begin
            exp_we = 1'b1; exp_a = 0; exp_d = REFW;
          end else begin
            k = (t_idx - 1) / 3 + 1;
            ph = (t_idx - 1) % 3;
            exp_we = (ph == 0);
            exp_a = (ph == 1) ? 0 : k;
            exp_d = pat_of(k);
          end
          if (mem_we != exp_we || int'(mem_addr) != exp_a ||
              (exp_we && mem_wdata != exp_d))
            n_seq_err <= n_seq_err + 1;
        end
        t_idx <= t_idx + 1;
        if (mem_we) begin
          n_wr <= n_wr + 1;
          if (int'(mem_addr) != drop_addr) mem[mem_addr[7:0] & alias_mask] <= mem_wdata;
        end else begin
          n_rd <= n_rd + 1;
          mem_rdata <= mem[mem_addr[7:0] & alias_mask];
        end
      end
    end
  end

  task automatic chk(input logic ok, input string tag, input logic [63:0] act,
                     input logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic prep(input logic [7:0] mask, input int drop);
    @(negedge clk);
    for (int i = 0; i < 256; i++) mem[i] = '0;
    alias_mask = mask;
    drop_addr = drop;
    n_wr = 0; n_rd = 0; n_seq_err = 0; n_late_req = 0; t_idx = 0;
  endtask

  task automatic kick(input int lim);
    @(negedge clk);
    scan_limit = AW'(lim);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic wait_done(input string tag);
    int n = 0;
    while (!done && n < 5000) begin
      @(negedge clk);
      n++;
    end
    chk(done, {tag, " done timeout"}, 64'(done), 64'd1);
  endtask

  task automatic t_reset;
    // R1
    chk(!done && !fail && !mem_req, "R1 flags after reset",
        {61'd0, done, fail, mem_req}, 64'd0);
    chk(fail_kind == 0 && fail_addr == 0 && fail_exp == 0 && fail_got == 0,
        "R1 fields after reset", {fail_exp, fail_got}, 64'd0);
  endtask

  task automatic t_pass(input int lim);
    prep(8'hFF, -1);
    kick(lim);
    // R8: start cleared status in the next cycle
    chk(!done && !fail, "R8 cleared by start", {62'd0, done, fail}, 64'd0);
    wait_done("R7 pass");
    chk(!fail, "R7 no fail on good memory", 64'(fail), 64'd0);
    chk(n_seq_err == 0, "R3 transfer order", 64'(n_seq_err), 64'd0);
    chk(n_wr == lim + 1, "R3 write count", 64'(n_wr), 64'(lim + 1));
    chk(n_rd == 2 * lim, "R7 read count", 64'(n_rd), 64'(2 * lim));
    chk(mem[0] == REFW, "R2 reference at address 0", 64'(mem[0]), 64'(REFW));
  endtask

  task automatic t_alias;
    // address bit 3 ignored: N=8 lands on address 0
    prep(8'hF7, -1);
    kick(20);
    wait_done("R4 alias");
    chk(fail && fail_kind == 2'b01, "R4 kind", {62'd0, fail_kind}, 64'd1);
    chk(fail_addr == 8, "R4 addr", 64'(fail_addr), 64'd8);
    chk(fail_exp == REFW, "R4 expected word", 64'(fail_exp), 64'(REFW));
    chk(fail_got == pat_of(8), "R4 got word", 64'(fail_got), 64'(pat_of(8)));
    chk(n_rd == 15 && n_wr == 9, "R6 stop after first failure",
        64'(n_rd * 100 + n_wr), 64'(1509));
    chk(n_seq_err == 0, "R3 order before alias", 64'(n_seq_err), 64'd0);
  endtask

  task automatic t_drop;
    logic [1:0] k0; logic [AW-1:0] a0; logic [31:0] e0, g0;
    prep(8'hFF, 5);
    kick(10);
    wait_done("R5 drop");
    chk(fail && fail_kind == 2'b10, "R5 kind", {62'd0, fail_kind}, 64'd2);
    chk(fail_addr == 5, "R5 addr", 64'(fail_addr), 64'd5);
    chk(fail_exp == pat_of(5), "R5 expected word", 64'(fail_exp), 64'(pat_of(5)));
    chk(fail_got == 0, "R5 got word", 64'(fail_got), 64'd0);
    k0 = fail_kind; a0 = fail_addr; e0 = fail_exp; g0 = fail_got;
    repeat (25) @(negedge clk);
    chk(done && fail && fail_kind == k0 && fail_addr == a0 && fail_exp == e0 &&
        fail_got == g0, "R8 fields hold", {fail_exp, fail_got}, {e0, g0});
    chk(n_late_req == 0, "R6 no requests after done", 64'(n_late_req), 64'd0);
  endtask

  task automatic t_hold_req;
    // R9: observe a request across its wait cycle
    logic [AW-1:0] a; logic w; logic [31:0] d;
    prep(8'hFF, -1);
    kick(2);
    chk(mem_req && !mem_ack, "R9 request open", {62'd0, mem_req, mem_ack}, 64'd2);
    a = mem_addr; w = mem_we; d = mem_wdata;
    @(negedge clk);
    chk(mem_req && mem_addr == a && mem_we == w && mem_wdata == d && mem_ack,
        "R9 request held until ack", 64'(mem_wdata), 64'(d));
    wait_done("R9 run");
    chk(!fail && n_seq_err == 0, "R9 run clean", 64'(n_seq_err), 64'd0);
  endtask

  initial begin
    rst_n = 1'b0; start = 1'b0; scan_limit = '0;
    alias_mask = 8'hFF; drop_addr = -1;
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_pass(20);
    t_pass(0);
    t_pass(1);
    t_alias();
    t_drop();
    t_pass(12);
    t_hold_req();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule